// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table held in memory. A miss supplies a 32-bit virtual address. The block latches that address together with the physical base of the top-level table. It then reads a directory entry and, if that entry is present, a leaf entry, through a single read port with variable latency. The result is the physical address with its effective access rights, ready to refill a translation cache, or a page fault that carries the virtual address that failed.

Pages are 4 KB. Each table level fills exactly one page of 32-bit entries, so each level has 1024 entries. A directory entry that is not present means the whole sub-tree is absent, so the walk stops after one read. Only one walk runs at a time. A busy output tells the requester to hold off.

Top module: `pgwalk_two_level`

## Requirements
- R1: On a successful walk, `out_paddr` equals the leaf entry's bits 31:12 followed by virtual address bits 11:0, which pass through unchanged.
- R2: The first read of a walk goes to address {latched base bits 31:12, vaddr bits 31:22, 2'b00}.
- R3: The second read goes to address {directory entry bits 31:12, vaddr bits 21:12, 2'b00}.
- R4: If the directory entry has bit 0 (present) clear, the walk ends with `done` and `fault` high after exactly one read, and `fault_vaddr` equals the missing virtual address.
- R5: If the leaf entry has bit 0 clear, the walk ends with a fault after exactly two reads, and `fault_vaddr` equals the virtual address.
- R6: With the default merge setting, `out_wr` is the AND of bit 1 of both entries and `out_user` is the AND of bit 2 of both entries.
- R7: `busy` rises in the cycle after a miss is accepted and falls in the cycle `done` is high. A miss or a base change presented while busy has no effect on the walk in progress and starts no read.
- R8: Each read is a single-cycle `mem_req` pulse. No new request is issued until `mem_rvalid` has returned the previous one, and the walker waits any number of cycles for it.
- R9: After reset `busy`, `done` and `mem_req` are low. `done` is a one-cycle pulse. On a fault, `out_paddr`, `out_wr` and `out_user` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Start a walk (taken only when not busy) |
| miss_vaddr | input | 32 | Virtual address to translate |
| table_base | input | 32 | Physical address of the top-level table (page aligned) |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Read address, valid with `mem_req` |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Table entry returned by memory |
| done | output | 1 | One-cycle pulse: walk finished |
| fault | output | 1 | With `done`: page fault |
| out_paddr | output | 32 | Translated physical address |
| out_wr | output | 1 | Effective write permission |
| out_user | output | 1 | Effective user permission |
| fault_vaddr | output | 32 | Faulting virtual address (zero on success) |

## Verification
The in-RTL assertions watch the handshake on every cycle. They check that requests are single-cycle pulses, that no request is issued while a read is still open or while idle, that `done` is a pulse that coincides with the end of busy, that `fault` only appears with `done`, and that a fault reports a zero address. The address each read goes to, the translated address and the merged rights, the early stop after a missing directory entry, and the immunity to misses issued mid-walk can only be shown by the bench's directed scenarios. Those scenarios run a table model over several latencies and index corners.

// File: rtl/pgwalk_pkg.sv
`timescale 1ns/1ps
package pgwalk_pkg;
   typedef enum logic [2:0] {
      WS_IDLE,
      WS_DIR_REQ,
      WS_DIR_WAIT,
      WS_LEAF_REQ,
      WS_LEAF_WAIT
   } walk_state_t;

   typedef struct packed {
      logic wr;
      logic usr;
   } perm_t;
endpackage

// File: rtl/pgwalk_index_gen.sv
`timescale 1ns/1ps
module pgwalk_index_gen #(
   parameter int VA_W   = 32,
   parameter int PA_W   = 32,
   parameter int OFS_W  = 12,
   parameter int IDX_W  = 10,
   parameter int ENT_LG = 2
) (
   input  logic [VA_W-1:0]       vaddr,
   input  logic [PA_W-1:0]       dir_base,
   input  logic [PA_W-OFS_W-1:0] leaf_frame,
   input  logic                  sel_leaf,
   output logic [PA_W-1:0]       rd_addr
);
   localparam int FRAME_W = PA_W - OFS_W;
   localparam int PAD_W   = OFS_W - IDX_W - ENT_LG;

   if (PAD_W < 0) begin : g_bad_geom
      $error("pgwalk_index_gen: table level larger than one page");
   end

   logic [IDX_W-1:0]   idx_dir, idx_leaf, idx_sel;
   logic [FRAME_W-1:0] frame_sel;

   assign idx_dir   = vaddr[VA_W-1 -: IDX_W];
   assign idx_leaf  = vaddr[OFS_W+IDX_W-1 -: IDX_W];
   assign idx_sel   = sel_leaf ? idx_leaf : idx_dir;
   assign frame_sel = sel_leaf ? leaf_frame : dir_base[PA_W-1:OFS_W];

   if (PAD_W > 0) begin : g_padded
      assign rd_addr = {frame_sel, {PAD_W{1'b0}}, idx_sel, {ENT_LG{1'b0}}};
   end else begin : g_packed
      assign rd_addr = {frame_sel, idx_sel, {ENT_LG{1'b0}}};
   end
endmodule

// File: rtl/pgwalk_entry_decode.sv
`timescale 1ns/1ps
module pgwalk_entry_decode
   import pgwalk_pkg::*;
#(
   parameter int ENT_W   = 32,
   parameter int FRAME_W = 20,
   parameter int V_BIT   = 0,
   parameter int W_BIT   = 1,
   parameter int U_BIT   = 2
) (
   input  logic [ENT_W-1:0]   entry,
   output logic               present,
   output logic [FRAME_W-1:0] frame,
   output perm_t              perm
);
   if (FRAME_W > ENT_W - 3) begin : g_bad_entry
      $error("pgwalk_entry_decode: no room for flag bits");
   end
   if (V_BIT >= ENT_W - FRAME_W || W_BIT >= ENT_W - FRAME_W || U_BIT >= ENT_W - FRAME_W) begin : g_bad_flags
      $error("pgwalk_entry_decode: flag bit overlaps frame field");
   end

   assign present  = entry[V_BIT];
   assign frame    = entry[ENT_W-1 -: FRAME_W];
   assign perm.wr  = entry[W_BIT];
   assign perm.usr = entry[U_BIT];
endmodule

// File: rtl/pgwalk_perm_merge.sv
`timescale 1ns/1ps
module pgwalk_perm_merge
   import pgwalk_pkg::*;
#(
   parameter bit MERGE = 1'b1
) (
   input  perm_t dir_perm,
   input  perm_t leaf_perm,
   output perm_t eff_perm
);
   if (MERGE) begin : g_and_levels
      assign eff_perm.wr  = dir_perm.wr  & leaf_perm.wr;
      assign eff_perm.usr = dir_perm.usr & leaf_perm.usr;
   end else begin : g_leaf_only
      assign eff_perm = leaf_perm;
   end
endmodule

// File: rtl/pgwalk_two_level.sv
`timescale 1ns/1ps
module pgwalk_two_level
   import pgwalk_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int PA_W        = 32,
   parameter int OFS_W       = 12,
   parameter int ENT_W       = 32,
   parameter bit MERGE_PERMS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             miss_valid,
   input  logic [VA_W-1:0]  miss_vaddr,
   input  logic [PA_W-1:0]  table_base,
   output logic             busy,
   output logic             mem_req,
   output logic [PA_W-1:0]  mem_addr,
   input  logic             mem_rvalid,
   input  logic [ENT_W-1:0] mem_rdata,
   output logic             done,
   output logic             fault,
   output logic [PA_W-1:0]  out_paddr,
   output logic             out_wr,
   output logic             out_user,
   output logic [VA_W-1:0]  fault_vaddr
);
   localparam int ENT_LG  = $clog2(ENT_W / 8);
   localparam int IDX_W   = OFS_W - ENT_LG;
   localparam int FRAME_W = PA_W - OFS_W;

   if (ENT_W % 8 != 0 || (1 << ENT_LG) * 8 != ENT_W) begin : g_bad_ent
      $error("pgwalk_two_level: entry width must be a power-of-two byte count");
   end
   if (VA_W != 2 * IDX_W + OFS_W) begin : g_bad_va
      $error("pgwalk_two_level: two levels must exactly cover the virtual address");
   end

   walk_state_t         state;
   logic [VA_W-1:0]     va_q;
   logic [PA_W-1:0]     base_q;
   logic [FRAME_W-1:0]  dir_frame_q;
   perm_t               dir_perm_q;
   logic                done_q, fault_q;
   logic [PA_W-1:0]     paddr_q;
   perm_t               perm_q;
   logic [VA_W-1:0]     fvaddr_q;

   logic                ent_present;
   logic [FRAME_W-1:0]  ent_frame;
   perm_t               ent_perm;
   perm_t               merged_perm;

   pgwalk_index_gen #(
      .VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .ENT_LG(ENT_LG)
   ) u_index (
      .vaddr      (va_q),
      .dir_base   (base_q),
      .leaf_frame (dir_frame_q),
      .sel_leaf   (state == WS_LEAF_REQ),
      .rd_addr    (mem_addr)
   );

   pgwalk_entry_decode #(
      .ENT_W(ENT_W), .FRAME_W(FRAME_W)
   ) u_decode (
      .entry   (mem_rdata),
      .present (ent_present),
      .frame   (ent_frame),
      .perm    (ent_perm)
   );

   pgwalk_perm_merge #(
      .MERGE(MERGE_PERMS)
   ) u_merge (
      .dir_perm  (dir_perm_q),
      .leaf_perm (ent_perm),
      .eff_perm  (merged_perm)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= WS_IDLE;
         va_q        <= '0;
         base_q      <= '0;
         dir_frame_q <= '0;
         dir_perm_q  <= '0;
         done_q      <= 1'b0;
         fault_q     <= 1'b0;
         paddr_q     <= '0;
         perm_q      <= '0;
         fvaddr_q    <= '0;
      end else begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         unique case (state)
            WS_IDLE: begin
               if (miss_valid) begin
                  va_q   <= miss_vaddr;
                  base_q <= table_base;
                  state  <= WS_DIR_REQ;
               end
            end
            WS_DIR_REQ: state <= WS_DIR_WAIT;
            WS_DIR_WAIT: begin
               if (mem_rvalid) begin
                  if (!ent_present) begin
                     done_q   <= 1'b1;
                     fault_q  <= 1'b1;
                     fvaddr_q <= va_q;
                     paddr_q  <= '0;
                     perm_q   <= '0;
                     state    <= WS_IDLE;
                  end else begin
                     dir_frame_q <= ent_frame;
                     dir_perm_q  <= ent_perm;
                     state       <= WS_LEAF_REQ;
                  end
               end
            end
            WS_LEAF_REQ: state <= WS_LEAF_WAIT;
            WS_LEAF_WAIT: begin
               if (mem_rvalid) begin
                  done_q <= 1'b1;
                  state  <= WS_IDLE;
                  if (!ent_present) begin
                     fault_q  <= 1'b1;
                     fvaddr_q <= va_q;
                     paddr_q  <= '0;
                     perm_q   <= '0;
                  end else begin
                     fvaddr_q <= '0;
                     paddr_q  <= {ent_frame, va_q[OFS_W-1:0]};
                     perm_q   <= merged_perm;
                  end
               end
            end
            default: state <= WS_IDLE;
         endcase
      end
   end

   assign busy        = (state != WS_IDLE);
   assign mem_req     = (state == WS_DIR_REQ) || (state == WS_LEAF_REQ);
   assign done        = done_q;
   assign fault       = fault_q;
   assign out_paddr   = paddr_q;
   assign out_wr      = perm_q.wr;
   assign out_user    = perm_q.usr;
   assign fault_vaddr = fvaddr_q;

   // Tracks a read that has been requested and not yet answered.
   logic rd_open;
   always_ff @(posedge clk) begin
      if (!rst_n)          rd_open <= 1'b0;
      else if (mem_req)    rd_open <= 1'b1;
      else if (mem_rvalid) rd_open <= 1'b0;
   end

   assert_req_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
   assert_single_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !rd_open);
   assert_req_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);
   assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && miss_valid) |=> busy);
   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_fault_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> done);
   assert_fault_zero_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (out_paddr == '0 && !out_wr && !out_user));
endmodule

// File: tb/test_pgwalk_two_level.sv
`timescale 1ns/1ps
module test_pgwalk_two_level;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        miss_valid = 1'b0;
   logic [31:0] miss_vaddr = '0;
   logic [31:0] table_base = '0;
   logic        busy, mem_req, done, fault, out_wr, out_user;
   logic [31:0] mem_addr, out_paddr, fault_vaddr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   pgwalk_two_level i_pgwalk_two_level (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vaddr(miss_vaddr),
      .table_base(table_base), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done), .fault(fault),
      .out_paddr(out_paddr), .out_wr(out_wr), .out_user(out_user),
      .fault_vaddr(fault_vaddr)
   );

   // Table memory model
   logic [31:0] tmem [logic [31:0]];
   int          mem_lat = 0;
   int          rd_total = 0;
   logic [31:0] rd_log [0:7];
   logic        pend = 1'b0;
   int          pcnt = 0;
   logic [31:0] paddr_pend = '0;

   function automatic logic [31:0] lookup(logic [31:0] a);
      return tmem.exists(a) ? tmem[a] : 32'h0;
   endfunction

   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (!rst_n) begin
         pend <= 1'b0;
      end else if (mem_req) begin
         pend       <= 1'b1;
         pcnt       <= mem_lat;
         paddr_pend <= mem_addr;
         rd_log[rd_total % 8] <= mem_addr;
         rd_total   <= rd_total + 1;
      end else if (pend) begin
         if (pcnt == 0) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= lookup(paddr_pend);
            pend       <= 1'b0;
         end else begin
            pcnt <= pcnt - 1;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   int          r_start;
   logic        r_fault, r_wr, r_user;
   logic [31:0] r_paddr, r_fva;

   task automatic start_walk(input logic [31:0] va, input int lat);
      mem_lat = lat;
      @(negedge clk);
      r_start    = rd_total;
      miss_vaddr = va;
      miss_valid = 1'b1;
      @(negedge clk);
      miss_valid = 1'b0;
   endtask

   task automatic wait_done();
      int t = 0;
      while (!done && t < 300) begin
         @(negedge clk);
         t++;
      end
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R8: walk never finished, actual 0 expected 1");
      end
      r_fault = fault; r_wr = out_wr; r_user = out_user;
      r_paddr = out_paddr; r_fva = fault_vaddr;
   endtask

   task automatic t_reset();
      chk("R9 busy after reset", {31'b0, busy}, 32'd0);
      chk("R9 done after reset", {31'b0, done}, 32'd0);
      chk("R9 mem_req after reset", {31'b0, mem_req}, 32'd0);
   endtask

   task automatic t_basic();
      start_walk(32'h0040_3ABC, 0);
      chk("R7 busy after accept", {31'b0, busy}, 32'd1);
      wait_done();
      chk("R7 busy low at done", {31'b0, busy}, 32'd0);
      chk("R1 paddr", r_paddr, 32'h0ABC_DABC);
      chk("R1 no fault", {31'b0, r_fault}, 32'd0);
      chk("R2 dir read addr", rd_log[r_start % 8], 32'h0001_0004);
      chk("R3 leaf read addr", rd_log[(r_start + 1) % 8], 32'h0002_000C);
      chk("R6 wr", {31'b0, r_wr}, 32'd1);
      chk("R6 user", {31'b0, r_user}, 32'd1);
      chk("R5 fault_vaddr zero on success", r_fva, 32'd0);
      @(negedge clk);
      chk("R9 done one cycle", {31'b0, done}, 32'd0);
   endtask

   task automatic t_second_leaf();
      start_walk(32'h0041_0123, 3);
      wait_done();
      chk("R1 paddr leaf16", r_paddr, 32'h0005_5123);
      chk("R3 leaf16 addr", rd_log[(r_start + 1) % 8], 32'h0002_0040);
      chk("R6 user off in leaf", {31'b0, r_user}, 32'd0);
      chk("R6 wr leaf16", {31'b0, r_wr}, 32'd1);
   endtask

   task automatic t_perm_merge();
      start_walk(32'h0080_5FFF, 2);
      wait_done();
      chk("R2 dir idx2 addr", rd_log[r_start % 8], 32'h0001_0008);
      chk("R3 leaf idx5 addr", rd_log[(r_start + 1) % 8], 32'h0003_0014);
      chk("R1 paddr full offset", r_paddr, 32'h0007_7FFF);
      chk("R6 dir denies write", {31'b0, r_wr}, 32'd0);
      chk("R6 user allowed", {31'b0, r_user}, 32'd1);
   endtask

   task automatic t_top_corner();
      start_walk(32'hFFFF_F001, 7);
      wait_done();
      chk("R2 last dir addr", rd_log[r_start % 8], 32'h0001_0FFC);
      chk("R3 last leaf addr", rd_log[(r_start + 1) % 8], 32'h0004_0FFC);
      chk("R1 paddr top", r_paddr, 32'hFFFF_F001);
      chk("R6 wr masked by dir", {31'b0, r_wr}, 32'd0);
      chk("R6 user masked by dir", {31'b0, r_user}, 32'd0);
   endtask

   task automatic t_dir_fault();
      start_walk(32'h0FC0_0000, 4);
      wait_done();
      chk("R4 fault", {31'b0, r_fault}, 32'd1);
      chk("R4 fault_vaddr", r_fva, 32'h0FC0_0000);
      chk("R9 paddr zero on fault", r_paddr, 32'd0);
      repeat (12) @(negedge clk);
      chk("R4 single read", rd_total - r_start, 32'd1);
      chk("R2 dir idx63 addr", rd_log[r_start % 8], 32'h0001_00FC);
   endtask

   task automatic t_leaf_fault();
      start_walk(32'h0040_9000, 1);
      wait_done();
      chk("R5 fault", {31'b0, r_fault}, 32'd1);
      chk("R5 fault_vaddr", r_fva, 32'h0040_9000);
      chk("R5 two reads", rd_total - r_start, 32'd2);
      chk("R9 perms zero on fault", {30'b0, r_wr, r_user}, 32'd0);
   endtask

   task automatic t_busy_ignore();
      start_walk(32'h0040_3ABC, 6);
      @(negedge clk);
      miss_vaddr = 32'h0FC0_0000;
      table_base = 32'h0009_0000;
      miss_valid = 1'b1;
      repeat (3) @(negedge clk);
      miss_valid = 1'b0;
      wait_done();
      chk("R7 result unaffected", r_paddr, 32'h0ABC_DABC);
      chk("R7 no fault from ignored miss", {31'b0, r_fault}, 32'd0);
      repeat (12) @(negedge clk);
      chk("R7 no extra reads", rd_total - r_start, 32'd2);
      chk("R7 idle after walk", {31'b0, busy}, 32'd0);
      table_base = 32'h0001_0000;
   endtask

   initial begin
      tmem[32'h0001_0004] = 32'h0002_0007;
      tmem[32'h0002_000C] = 32'h0ABC_D007;
      tmem[32'h0002_0040] = 32'h0005_5003;
      tmem[32'h0001_0008] = 32'h0003_0005;
      tmem[32'h0003_0014] = 32'h0007_7007;
      tmem[32'h0001_0FFC] = 32'h0004_0001;
      tmem[32'h0004_0FFC] = 32'hFFFF_F007;
      tmem[32'h0002_0024] = 32'h0009_9006;
      table_base = 32'h0001_0000;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_second_leaf();
      t_perm_merge();
      t_top_corner();
      t_dir_fault();
      t_leaf_fault();
      t_busy_ignore();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL R8: watchdog expired, actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule